// File: doc/BRIEF.md
# 8b/10b Symbol Decoder with Error Reporting

This block turns one aligned 10-bit line symbol per clock into a byte and a control flag. It keeps the receive running disparity and reports two separate faults. A disparity fault means the symbol is a real code word but the wrong one for the current disparity. A code fault means the symbol is no code word at all. A comma flag is also raised, and a 3-bit mode input picks what counts as a comma. Every output is registered, so results appear one clock after the symbol is presented.

A bypass input lets raw 10-bit symbols through without decoding. The upper two symbol bits then appear on the control and disparity outputs. Word alignment, elastic buffering and multi-lane handling belong to the blocks around this one.

Top module: `dec8b10b`

## Requirements
- R1: While `rst_n` is low, every output is 0 and the running disparity state is negative (0 = negative, 1 = positive).
- R2: Symbol bits are ordered `sym_i[9:4]` = abcdei (a at bit 9) and `sym_i[3:0]` = fghj (f at bit 3). A legal data symbol D.x.y yields `data_o` = {y[2:0], x[4:0]} with `ctrl_o` = 0, one clock after it is presented.
- R3: The twelve control symbols K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 yield their byte value with `ctrl_o` = 1.
- R4: After each decoded symbol, `rd_o` shows the running disparity left by that symbol. Each sub-block sets it by sign: more ones gives positive and fewer gives negative. A balanced sub-block leaves it unchanged, except that 000111 and 0011 force positive and 111000 and 1100 force negative.
- R5: `disp_err_o` is 1 when the symbol is a code word for one starting disparity but not for the current one. It is 0 for a symbol legal in both. The byte and control flag are still decoded, and the disparity still follows R4.
- R6: `nit_err_o` is 1 when the symbol is not a code word for either starting disparity. `disp_err_o` is then 0.
- R7: On a code fault, `ctrl_o` = `sym_i[9]`, `rd_o` = `sym_i[8]` and `data_o` = `sym_i[7:0]`. The internal running disparity is still updated by the R4 rule.
- R8: With `bypass_i` = 1, `ctrl_o` = `sym_i[9]`, `rd_o` = `sym_i[8]`, `data_o` = `sym_i[7:0]`, and both fault flags are 0. The running disparity state is held unchanged.
- R9: Comma modes 0, 1 and 2 flag any symbol whose `sym_i[9:3]` equals 0011111 (plus), 1100000 (minus), or either of the two. This holds whether or not the symbol is a code word.
- R10: Comma modes 3, 4 and 5 flag only K28.1, K28.5 and K28.7. Mode 3 takes the plus form (0011111001, 0011111010, 0011111000), mode 4 the minus form (1100000110, 1100000101, 1100000111), and mode 5 either. Modes 6 and 7 never flag.
- R11: `comma_o` is registered like the other outputs and works the same way in bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_i | input | 10 | Aligned line symbol, bit 9 first on the wire |
| bypass_i | input | 1 | 1 = pass raw symbol, no decoding |
| comma_mode_i | input | 3 | Comma definition select, 0 to 7 |
| data_o | output | 8 | Decoded byte or raw low bits |
| ctrl_o | output | 1 | Control-symbol flag or raw bit 9 |
| disp_err_o | output | 1 | Wrong-disparity code word |
| nit_err_o | output | 1 | Symbol is not a code word |
| rd_o | output | 1 | Running disparity after the symbol, or raw bit 8 |
| comma_o | output | 1 | Comma seen under the selected mode |

## Verification
The assertions check on every cycle that the two fault flags are never raised together. They also check the raw bit mapping in bypass and on code faults, the absence of faults in bypass, the silent comma modes, the either-pattern comma mode, and that a control-only comma always comes with the control flag. Correct byte values, the exact running disparity sequence across alternate codings, and the choice between a disparity fault and a code fault depend on the code table and the symbol history. Only the bench's directed streams show those. The bench also shows that a code fault or a bypassed symbol leaves the later disparity where R4 and R8 say it should be.

// File: rtl/dec8b10b_pkg.sv
// Package: shared widths, comma mode encoding and the 8b/10b code rules.
// The encoder functions are used only with constant arguments inside the
// lookup, so they fold into fixed comparisons.
package dec8b10b_pkg;
    localparam int SYM_W  = 10;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        CM_PAT_P = 3'd0,
        CM_PAT_N = 3'd1,
        CM_PAT_B = 3'd2,
        CM_K_P   = 3'd3,
        CM_K_N   = 3'd4,
        CM_K_B   = 3'd5,
        CM_OFF_A = 3'd6,
        CM_OFF_B = 3'd7
    } comma_mode_e;

    // 6-bit sub-block for data value x when the starting disparity is negative
    function automatic logic [5:0] six_neg(input logic [4:0] x);
        case (x)
            5'd0:  six_neg = 6'b100111;  5'd1:  six_neg = 6'b011101;
            5'd2:  six_neg = 6'b101101;  5'd3:  six_neg = 6'b110001;
            5'd4:  six_neg = 6'b110101;  5'd5:  six_neg = 6'b101001;
            5'd6:  six_neg = 6'b011001;  5'd7:  six_neg = 6'b111000;
            5'd8:  six_neg = 6'b111001;  5'd9:  six_neg = 6'b100101;
            5'd10: six_neg = 6'b010101;  5'd11: six_neg = 6'b110100;
            5'd12: six_neg = 6'b001101;  5'd13: six_neg = 6'b101100;
            5'd14: six_neg = 6'b011100;  5'd15: six_neg = 6'b010111;
            5'd16: six_neg = 6'b011011;  5'd17: six_neg = 6'b100011;
            5'd18: six_neg = 6'b010011;  5'd19: six_neg = 6'b110010;
            5'd20: six_neg = 6'b001011;  5'd21: six_neg = 6'b101010;
            5'd22: six_neg = 6'b011010;  5'd23: six_neg = 6'b111010;
            5'd24: six_neg = 6'b110011;  5'd25: six_neg = 6'b100110;
            5'd26: six_neg = 6'b010110;  5'd27: six_neg = 6'b110110;
            5'd28: six_neg = 6'b001110;  5'd29: six_neg = 6'b101110;
            5'd30: six_neg = 6'b011110;  default: six_neg = 6'b101011;
        endcase
    endfunction

    // Disparity left after a 6-bit sub-block
    function automatic logic rd_after6(input logic [5:0] c, input logic rd);
        int n;
        n = $countones(c);
        if (n > 3)                 rd_after6 = 1'b1;
        else if (n < 3)            rd_after6 = 1'b0;
        else if (c == 6'b000111)   rd_after6 = 1'b1;
        else if (c == 6'b111000)   rd_after6 = 1'b0;
        else                       rd_after6 = rd;
    endfunction

    // Disparity left after a 4-bit sub-block
    function automatic logic rd_after4(input logic [3:0] c, input logic rd);
        int n;
        n = $countones(c);
        if (n > 2)                 rd_after4 = 1'b1;
        else if (n < 2)            rd_after4 = 1'b0;
        else if (c == 4'b0011)     rd_after4 = 1'b1;
        else if (c == 4'b1100)     rd_after4 = 1'b0;
        else                       rd_after4 = rd;
    endfunction

    // 6-bit sub-block for data value x at starting disparity rd
    function automatic logic [5:0] six_enc(input logic [4:0] x, input logic rd);
        logic [5:0] b;
        b = six_neg(x);
        if (rd && (($countones(b) != 3) || (x == 5'd7))) six_enc = ~b;
        else                                             six_enc = b;
    endfunction

    // 4-bit sub-block for y at disparity rd; alt selects the alternate y=7 code
    function automatic logic [3:0] four_enc(input logic [2:0] y, input logic rd,
                                            input logic alt, input logic k28);
        logic [3:0] b;
        case (y)
            3'd0: b = 4'b1011;  3'd1: b = 4'b1001;
            3'd2: b = 4'b0101;  3'd3: b = 4'b1100;
            3'd4: b = 4'b1101;  3'd5: b = 4'b1010;
            3'd6: b = 4'b0110;  default: b = alt ? 4'b0111 : 4'b1110;
        endcase
        if (k28 && (($countones(b) == 2) && (y != 3'd3)))
            four_enc = rd ? b : ~b;
        else if (rd && (($countones(b) != 2) || (y == 3'd3) || (y == 3'd7)))
            four_enc = ~b;
        else
            four_enc = b;
    endfunction

    // True for the twelve legal control byte values
    function automatic logic k_legal(input logic [7:0] v);
        k_legal = (v[4:0] == 5'd28) || (v == 8'hF7) || (v == 8'hFB) ||
                  (v == 8'hFD) || (v == 8'hFE);
    endfunction

    // Full 10-bit code word for byte v, control flag k, starting disparity rd
    function automatic logic [9:0] sym_enc(input logic [7:0] v, input logic k,
                                           input logic rd);
        logic [4:0] x;
        logic [2:0] y;
        logic       k28, mid, alt;
        logic [5:0] c6;
        x   = v[4:0];
        y   = v[7:5];
        k28 = k && (x == 5'd28);
        c6  = k28 ? (rd ? 6'b110000 : 6'b001111) : six_enc(x, rd);
        mid = rd_after6(c6, rd);
        alt = (y == 3'd7) && (k ||
              (!mid && ((x == 5'd17) || (x == 5'd18) || (x == 5'd20))) ||
              ( mid && ((x == 5'd11) || (x == 5'd13) || (x == 5'd14))));
        sym_enc = {c6, four_enc(y, mid, alt, k28)};
    endfunction
endpackage

// File: rtl/dec8b10b_lookup.sv
// Code table search: reports whether the symbol is a code word for a negative
// start, for a positive start, and the byte and control flag it carries.
// Assumes a combinational use; all encoder calls have constant arguments.
module dec8b10b_lookup
    import dec8b10b_pkg::*;
(
    input  logic [SYM_W-1:0]  sym_i,
    output logic              hit_neg_o,
    output logic              hit_pos_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              is_k_o
);
    localparam int N_CAND = 2 << BYTE_W;

    // Compare the symbol against every data and control code word
    always_comb begin
        hit_neg_o = 1'b0;
        hit_pos_o = 1'b0;
        byte_o    = '0;
        is_k_o    = 1'b0;
        for (int i = 0; i < N_CAND; i++) begin
            if (!i[BYTE_W] || k_legal(i[BYTE_W-1:0])) begin
                if (sym_i == sym_enc(i[BYTE_W-1:0], i[BYTE_W], 1'b0)) begin
                    hit_neg_o = 1'b1;
                    byte_o    = i[BYTE_W-1:0];
                    is_k_o    = i[BYTE_W];
                end
                if (sym_i == sym_enc(i[BYTE_W-1:0], i[BYTE_W], 1'b1)) begin
                    hit_pos_o = 1'b1;
                    byte_o    = i[BYTE_W-1:0];
                    is_k_o    = i[BYTE_W];
                end
            end
        end
    end
endmodule

// File: rtl/dec8b10b_rdcalc.sv
// Running disparity step: disparity after a symbol, from the disparity before
// it. Works for any 10-bit pattern, code word or not.
module dec8b10b_rdcalc
    import dec8b10b_pkg::*;
(
    input  logic [SYM_W-1:0] sym_i,
    input  logic             rd_i,
    output logic             rd_o
);
    logic rd_mid;

    // Apply the 6-bit then the 4-bit sub-block rule
    always_comb begin
        rd_mid = rd_after6(sym_i[9:4], rd_i);
        rd_o   = rd_after4(sym_i[3:0], rd_mid);
    end
endmodule

// File: rtl/dec8b10b_comma.sv
// Comma classifier for the six detection modes; modes 6 and 7 are silent.
// Looks at the raw symbol only, so it needs no disparity or table result.
module dec8b10b_comma
    import dec8b10b_pkg::*;
(
    input  logic [SYM_W-1:0]  sym_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              comma_o
);
    localparam int          N_KC   = 3;
    localparam logic [6:0]  PAT_P  = 7'b0011111;
    localparam logic [6:0]  PAT_N  = ~PAT_P;
    localparam logic [2:0]  KC_Y [N_KC] = '{3'd1, 3'd5, 3'd7};

    logic [N_KC-1:0] kp_hit, kn_hit;
    logic            pat_p, pat_n, any_kp, any_kn;

    // One comparator pair per comma-bearing control symbol
    for (genvar g = 0; g < N_KC; g++) begin : g_kc
        assign kp_hit[g] = (sym_i == sym_enc({KC_Y[g], 5'd28}, 1'b1, 1'b0));
        assign kn_hit[g] = (sym_i == sym_enc({KC_Y[g], 5'd28}, 1'b1, 1'b1));
    end

    // Select the comma definition named by the mode
    always_comb begin
        pat_p  = (sym_i[9:3] == PAT_P);
        pat_n  = (sym_i[9:3] == PAT_N);
        any_kp = |kp_hit;
        any_kn = |kn_hit;
        case (comma_mode_e'(mode_i))
            CM_PAT_P: comma_o = pat_p;
            CM_PAT_N: comma_o = pat_n;
            CM_PAT_B: comma_o = pat_p | pat_n;
            CM_K_P:   comma_o = any_kp;
            CM_K_N:   comma_o = any_kn;
            CM_K_B:   comma_o = any_kp | any_kn;
            default:  comma_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dec8b10b.sv
// Top: 8b/10b symbol decoder with one-cycle registered outputs, split fault
// flags, raw pass-through on bypass or on a non-code symbol, and a comma flag.
// Assumes symbols arrive already aligned, one per clock.
module dec8b10b
    import dec8b10b_pkg::*;
#(
    parameter logic INIT_RD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYM_W-1:0]  sym_i,
    input  logic              bypass_i,
    input  logic [MODE_W-1:0] comma_mode_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              ctrl_o,
    output logic              disp_err_o,
    output logic              nit_err_o,
    output logic              rd_o,
    output logic              comma_o
);
    logic              rd_q, rd_nx;
    logic              hit_neg, hit_pos, is_k, comma_c;
    logic [BYTE_W-1:0] dec_byte;
    logic              in_tab, fits_rd;

    dec8b10b_lookup u_lookup (
        .sym_i     (sym_i),
        .hit_neg_o (hit_neg),
        .hit_pos_o (hit_pos),
        .byte_o    (dec_byte),
        .is_k_o    (is_k)
    );

    dec8b10b_rdcalc u_rdcalc (
        .sym_i (sym_i),
        .rd_i  (rd_q),
        .rd_o  (rd_nx)
    );

    dec8b10b_comma u_comma (
        .sym_i   (sym_i),
        .mode_i  (comma_mode_i),
        .comma_o (comma_c)
    );

    // Classify the symbol against the current disparity
    always_comb begin
        in_tab  = hit_neg | hit_pos;
        fits_rd = rd_q ? hit_pos : hit_neg;
    end

    // Register outputs and advance the running disparity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q       <= INIT_RD;
            data_o     <= '0;
            ctrl_o     <= 1'b0;
            disp_err_o <= 1'b0;
            nit_err_o  <= 1'b0;
            rd_o       <= 1'b0;
            comma_o    <= 1'b0;
        end else begin
            comma_o <= comma_c;
            if (bypass_i || !in_tab) begin
                data_o     <= sym_i[7:0];
                ctrl_o     <= sym_i[9];
                rd_o       <= sym_i[8];
                disp_err_o <= 1'b0;
                nit_err_o  <= !bypass_i;
                if (!bypass_i) rd_q <= rd_nx;
            end else begin
                data_o     <= dec_byte;
                ctrl_o     <= is_k;
                rd_o       <= rd_nx;
                disp_err_o <= !fits_rd;
                nit_err_o  <= 1'b0;
                rd_q       <= rd_nx;
            end
        end
    end
endmodule

// Checker: port-level properties of the decoder, bound to every instance.
// Assumes inputs are driven from time zero.
module dec8b10b_chk
    import dec8b10b_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SYM_W-1:0]  sym_i,
    input logic              bypass_i,
    input logic [MODE_W-1:0] comma_mode_i,
    input logic [BYTE_W-1:0] data_o,
    input logic              ctrl_o,
    input logic              disp_err_o,
    input logic              nit_err_o,
    input logic              rd_o,
    input logic              comma_o
);
    logic armed;

    // Mark cycles whose outputs come from a capture taken out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !(disp_err_o && nit_err_o));

    p_nit_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && nit_err_o) |-> ({ctrl_o, rd_o, data_o} == $past(sym_i)));

    p_bypass_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(bypass_i)) |-> ({ctrl_o, rd_o, data_o} == $past(sym_i)));

    p_bypass_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(bypass_i)) |-> (!disp_err_o && !nit_err_o));

    p_comma_pat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(comma_mode_i) == 3'd2)) |->
        (comma_o == (($past(sym_i[9:3]) == 7'b0011111) ||
                     ($past(sym_i[9:3]) == 7'b1100000))));

    p_comma_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(comma_mode_i[2:1]) == 2'b11)) |-> !comma_o);

    p_kcomma_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(bypass_i) && ($past(comma_mode_i) >= 3'd3) &&
         ($past(comma_mode_i) <= 3'd5) && comma_o) |-> (ctrl_o && !nit_err_o));
endmodule

bind dec8b10b dec8b10b_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_i        (sym_i),
    .bypass_i     (bypass_i),
    .comma_mode_i (comma_mode_i),
    .data_o       (data_o),
    .ctrl_o       (ctrl_o),
    .disp_err_o   (disp_err_o),
    .nit_err_o    (nit_err_o),
    .rd_o         (rd_o),
    .comma_o      (comma_o)
);

// File: tb/tb_dec8b10b.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_dec8b10b;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] sym = 10'b1010101010;
    logic       byp = 1'b0;
    logic [2:0] mode = 3'd7;
    logic [7:0] data_o;
    logic       ctrl_o, disp_err_o, nit_err_o, rd_o, comma_o;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    dec8b10b dut (
        .clk (clk), .rst_n (rst_n), .sym_i (sym), .bypass_i (byp),
        .comma_mode_i (mode), .data_o (data_o), .ctrl_o (ctrl_o),
        .disp_err_o (disp_err_o), .nit_err_o (nit_err_o), .rd_o (rd_o),
        .comma_o (comma_o)
    );

    function automatic logic [12:0] ev(input logic [7:0] d, input logic c,
        input logic de, input logic ni, input logic r, input logic cm);
        ev = {d, c, de, ni, r, cm};
    endfunction

    function automatic logic [12:0] act();
        act = {data_o, ctrl_o, disp_err_o, nit_err_o, rd_o, comma_o};
    endfunction

    task automatic chk(input string req, input logic [12:0] a, input logic [12:0] e);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (data,ctrl,derr,nit,rd,comma)", req, a, e);
        end
    endtask

    task automatic drive(input logic [9:0] s, input logic b, input logic [2:0] m);
        @(negedge clk);
        sym = s; byp = b; mode = m;
        @(posedge clk);
        #1;
    endtask

    // R1: reset values, then release with a neutral idle symbol
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; sym = 10'b1010101010; byp = 1'b0; mode = 3'd7;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", act(), ev(8'h00, 0, 0, 0, 0, 0));
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R2 R4: data symbols including alternate y=7 codings
    task automatic t_data();
        t_reset();
        drive(10'b1010101010, 0, 7); chk("R2 D.21.5", act(), ev(8'hB5, 0, 0, 0, 0, 0));
        drive(10'b1100011011, 0, 7); chk("R4 D.3.0-", act(), ev(8'h03, 0, 0, 0, 1, 0));
        drive(10'b1100010100, 0, 7); chk("R4 D.3.0+", act(), ev(8'h03, 0, 0, 0, 0, 0));
        drive(10'b1000110111, 0, 7); chk("R2 D.17.7 alt", act(), ev(8'hF1, 0, 0, 0, 1, 0));
        drive(10'b1101001000, 0, 7); chk("R2 D.11.7 alt", act(), ev(8'hEB, 0, 0, 0, 0, 0));
        drive(10'b1110001110, 0, 7); chk("R4 D.7.7", act(), ev(8'hE7, 0, 0, 0, 1, 0));
    endtask

    // R3 R4: control symbols at both disparities
    task automatic t_ctrl();
        t_reset();
        drive(10'b1100011011, 0, 7); chk("R4 to positive", act(), ev(8'h03, 0, 0, 0, 1, 0));
        drive(10'b1100000101, 0, 7); chk("R3 K28.5+", act(), ev(8'hBC, 1, 0, 0, 0, 0));
        drive(10'b0011111010, 0, 7); chk("R3 K28.5-", act(), ev(8'hBC, 1, 0, 0, 1, 0));
        drive(10'b1100000111, 0, 7); chk("R3 K28.7+", act(), ev(8'hFC, 1, 0, 0, 1, 0));
        drive(10'b0001010111, 0, 7); chk("R3 K23.7+", act(), ev(8'hF7, 1, 0, 0, 1, 0));
        drive(10'b1100001011, 0, 7); chk("R3 K28.0+", act(), ev(8'h1C, 1, 0, 0, 1, 0));
    endtask

    // R5: code words of the wrong disparity
    task automatic t_disp();
        t_reset();
        drive(10'b1100000101, 0, 7); chk("R5 K28.5+ at neg", act(), ev(8'hBC, 1, 1, 0, 0, 0));
        drive(10'b1100010100, 0, 7); chk("R5 D.3.0+ at neg", act(), ev(8'h03, 0, 1, 0, 0, 0));
        drive(10'b1010101010, 0, 7); chk("R5 neutral no error", act(), ev(8'hB5, 0, 0, 0, 0, 0));
    endtask

    // R6 R7: non-code symbols, raw output and disparity still tracked
    task automatic t_nit();
        t_reset();
        drive(10'b0000001111, 0, 7); chk("R6 R7 bad 6b", act(), ev(8'h0F, 0, 0, 1, 0, 0));
        drive(10'b1100010100, 0, 7); chk("R7 rd advanced", act(), ev(8'h03, 0, 0, 0, 0, 0));
        drive(10'b1110000001, 0, 7); chk("R6 R7 bad pair", act(), ev(8'h81, 1, 0, 1, 1, 0));
        drive(10'b1100011011, 0, 7); chk("R7 rd after pair", act(), ev(8'h03, 0, 0, 0, 1, 0));
    endtask

    // R8: bypass mapping, no faults, disparity held
    task automatic t_bypass();
        t_reset();
        drive(10'b1000000001, 1, 7); chk("R8 map a", act(), ev(8'h01, 1, 0, 0, 0, 0));
        drive(10'b0111111111, 1, 7); chk("R8 map b", act(), ev(8'hFF, 0, 0, 0, 1, 0));
        drive(10'b1100011011, 0, 7); chk("R8 rd held", act(), ev(8'h03, 0, 0, 0, 1, 0));
    endtask

    function automatic logic exp_comma(input logic [9:0] s, input logic [2:0] m);
        logic p, n, kp, kn;
        p  = (s[9:3] == 7'b0011111);
        n  = (s[9:3] == 7'b1100000);
        kp = (s == 10'b0011111001) || (s == 10'b0011111010) || (s == 10'b0011111000);
        kn = (s == 10'b1100000110) || (s == 10'b1100000101) || (s == 10'b1100000111);
        case (m)
            3'd0: exp_comma = p;       3'd1: exp_comma = n;
            3'd2: exp_comma = p | n;   3'd3: exp_comma = kp;
            3'd4: exp_comma = kn;      3'd5: exp_comma = kp | kn;
            default: exp_comma = 1'b0;
        endcase
    endfunction

    // R9 R10 R11: every mode against commas, a non-code comma and a non-comma
    task automatic t_comma();
        logic [9:0] pats [4];
        pats = '{10'b0011111010, 10'b1100000111, 10'b0011111111, 10'b0011110100};
        t_reset();
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 8; m++) begin
                drive(pats[p], 0, 3'(m));
                chk(m < 3 ? "R9 comma" : "R10 comma", {12'b0, comma_o},
                    {12'b0, exp_comma(pats[p], 3'(m))});
            end
        end
        drive(10'b1100000101, 1, 3'd5);
        chk("R11 comma in bypass", {12'b0, comma_o}, {12'b0, 1'b1});
        drive(10'b1100000101, 1, 3'd6);
        chk("R11 mode off in bypass", {12'b0, comma_o}, {12'b0, 1'b0});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_data();
        t_ctrl();
        t_disp();
        t_nit();
        t_bypass();
        t_comma();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule